// File: doc/BRIEF.md
# Lucas-Lehmer Mersenne Primality Engine

This block decides whether the Mersenne number 2^p − 1 is prime for an exponent p presented on a 16-bit input. A single-cycle start pulse captures the exponent and seeds a residue register with 4. The engine then runs p − 2 rounds of the recurrence S ← (S² − 2) mod (2^p − 1). At the end it raises `done` and reports `prime` high exactly when the final residue is zero.

The square is built serially. Each clock adds one partial product into an accumulator through an adder that works modulo 2^p − 1. A partial product is the residue rotated left by the bit index within a p-bit field. It is gated to zero when that bit of the residue is clear. The end-around carry of the adder performs the reduction, so no divider is needed. The running residue is visible on a debug output throughout the run, so a host or testbench can follow every round.

Top module: `lucas_lehmer_top`

## Requirements
- R1: After a synchronous reset, `done` and `prime` are low and `residue` reads zero.
- R2: A start pulse with an exponent in the range 3 to 16 captures the exponent and sets `residue` to 4 at the next edge. It also clears `done`.
- R3: Every round replaces the residue with (S² − 2) mod (2^p − 1). An intermediate square of 0 or 1 wraps to 2^p − 3 or 2^p − 2. The residue always stays in the range 0 to 2^p − 2.
- R4: After p − 2 rounds `done` goes high. `prime` is 1 exactly when the final residue is 0. For p = 7 the residues are 4, 14, 67, 42, 111, 0 and the result is prime. For p = 11 the run ends at 1736 and the result is not prime.
- R5: Each round takes exactly p clock cycles. `done` rises p·(p − 2) edges after the edge that sampled the start, and stays low before that.
- R6: While a run is in progress, start pulses and changes on the exponent input have no effect on the residue sequence or on the result.
- R7: Once `done` is high, it stays high, with `prime` and `residue` unchanged, until the next start. A new start launches a fresh run.
- R8: A start with an exponent below 3 or above 16 sets `done` high and `prime` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a test |
| exp_in | input | 16 | Mersenne exponent p, sampled on an accepted start |
| done | output | 1 | High when the test has finished |
| prime | output | 1 | Test result, valid while `done` is high |
| residue | output | 16 | Current Lucas-Lehmer residue, for debug |

## Verification
A fault in the serial squarer corrupts the residue at the first round boundary, p cycles after start. A mis-rotated partial product or a lost end-around carry therefore shows on `residue` long before `done` rises. An off-by-one in the partial-product index or the round counter moves the cycle where the residue changes or where `done` rises, so sampling on exact cycle boundaries exposes it. A corrupted final compare shows only as a wrong `prime` bit. For that reason both prime and composite exponents, several lengths, and the exponent bounds are run.

// File: rtl/llt_pkg.sv
package llt_pkg;

    // Widest supported Mersenne exponent, also the datapath width.
    localparam int unsigned LL_W    = 16;
    // Seed value of the recurrence.
    localparam int unsigned LL_SEED = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SQR  = 2'd1,
        ST_DONE = 2'd2
    } llt_state_e;

endpackage

// File: rtl/llt_modadd.sv
// Adder modulo 2^p - 1: end-around carry, all-ones folded to zero.
module llt_modadd #(
    parameter int unsigned W = llt_pkg::LL_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] mask,
    output logic [W-1:0] sum
);
    logic [W:0]   raw;
    logic         wrap;
    logic [W-1:0] folded;

    always_comb begin
        raw    = {1'b0, a} + {1'b0, b};
        // Any bit above the p-bit field is the carry that wraps around.
        wrap   = |(raw & ~{1'b0, mask});
        folded = (raw[W-1:0] & mask) + {{(W-1){1'b0}}, wrap};
        sum    = (folded == mask) ? '0 : folded;
    end
endmodule

// File: rtl/llt_pprod.sv
// One partial product of x*y mod 2^p - 1: y rotated left by idx inside p bits,
// gated by bit idx of x.
module llt_pprod #(
    parameter int unsigned W  = llt_pkg::LL_W,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  plen,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  pp
);
    logic [2*W-1:0] ext;
    logic [2*W-1:0] spill;
    logic [W-1:0]   rot;

    always_comb begin
        ext   = {{W{1'b0}}, y} << idx;
        spill = ext >> plen;
        rot   = (ext[W-1:0] & mask) | spill[W-1:0];
        pp    = x[idx] ? rot : '0;
    end
endmodule

// File: rtl/llt_sqr.sv
// Serial modular squarer: one partial product accumulated per enabled cycle.
module llt_sqr #(
    parameter int unsigned W  = llt_pkg::LL_W,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] opnd,
    input  logic [W-1:0] plen,
    input  logic [W-1:0] mask,
    output logic         last,
    output logic [W-1:0] sq
);
    logic [IW-1:0] idx_q;
    logic [W-1:0]  acc_q;
    logic [W-1:0]  pp;
    logic [W-1:0]  acc_nxt;
    logic [W-1:0]  idx_wide;

    llt_pprod #(.W(W), .IW(IW)) u_pp (
        .x    (opnd),
        .y    (opnd),
        .idx  (idx_q),
        .plen (plen),
        .mask (mask),
        .pp   (pp)
    );

    llt_modadd #(.W(W)) u_add (
        .a    (acc_q),
        .b    (pp),
        .mask (mask),
        .sum  (acc_nxt)
    );

    assign idx_wide = {{(W-IW){1'b0}}, idx_q};
    assign last     = en && (idx_wide == plen - W'(1));
    assign sq       = acc_nxt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (en) begin
            if (last) begin
                idx_q <= '0;
                acc_q <= '0;
            end else begin
                idx_q <= idx_q + IW'(1);
                acc_q <= acc_nxt;
            end
        end
    end

    // R5: the partial-product index never walks past the exponent
    assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
        en |-> (idx_wide < plen));

    // R3: the accumulator stays a reduced value
    assert_acc_reduced_R3: assert property (@(posedge clk) disable iff (rst)
        en |-> ((acc_q & ~mask) == '0 && acc_q != mask));
endmodule

// File: rtl/lucas_lehmer_top.sv
module lucas_lehmer_top #(
    parameter int unsigned W = llt_pkg::LL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] exp_in,
    output logic         done,
    output logic         prime,
    output logic [W-1:0] residue
);
    import llt_pkg::*;

    localparam int unsigned IW = $clog2(W);
    localparam logic [W-1:0] EXP_MIN = W'(3);
    localparam logic [W-1:0] EXP_MAX = W'(W);
    localparam logic [W-1:0] SEED    = W'(LL_SEED);

    typedef struct packed {
        logic [W-1:0] plen;
        logic [W-1:0] mask;
    } run_cfg_t;

    function automatic logic [W-1:0] mask_of(input logic [W-1:0] e);
        logic [W-1:0] m;
        for (int b = 0; b < W; b++) m[b] = (W'(b) < e);
        return m;
    endfunction

    function automatic logic [W-1:0] minus_two(input logic [W-1:0] v,
                                               input logic [W-1:0] m);
        return (v >= W'(2)) ? (v - W'(2)) : (m - W'(2) + v);
    endfunction

    llt_state_e    state_q;
    run_cfg_t      cfg_q;
    logic [IW-1:0] iter_q;
    logic [W-1:0]  residue_q;
    logic          done_q;
    logic          prime_q;

    logic          exp_ok;
    logic          accept;
    logic          busy;
    logic          sqr_last;
    logic [W-1:0]  sq;
    logic [W-1:0]  next_res;
    logic          final_round;

    assign busy        = (state_q == ST_SQR);
    assign exp_ok      = (exp_in >= EXP_MIN) && (exp_in <= EXP_MAX);
    assign accept      = start && !busy;
    assign next_res    = minus_two(sq, cfg_q.mask);
    assign final_round = ({{(W-IW){1'b0}}, iter_q} == cfg_q.plen - W'(3));

    llt_sqr #(.W(W), .IW(IW)) u_sqr (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .en    (busy),
        .opnd  (residue_q),
        .plen  (cfg_q.plen),
        .mask  (cfg_q.mask),
        .last  (sqr_last),
        .sq    (sq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            iter_q    <= '0;
            residue_q <= '0;
            done_q    <= 1'b0;
            prime_q   <= 1'b0;
        end else if (accept) begin
            if (exp_ok) begin
                state_q    <= ST_SQR;
                cfg_q.plen <= exp_in;
                cfg_q.mask <= mask_of(exp_in);
                iter_q     <= '0;
                residue_q  <= SEED;
                done_q     <= 1'b0;
                prime_q    <= 1'b0;
            end else begin
                state_q <= ST_DONE;
                done_q  <= 1'b1;
                prime_q <= 1'b0;
            end
        end else if (busy && sqr_last) begin
            residue_q <= next_res;
            iter_q    <= iter_q + IW'(1);
            if (final_round) begin
                state_q <= ST_DONE;
                done_q  <= 1'b1;
                prime_q <= (next_res == '0);
            end
        end
    end

    assign done    = done_q;
    assign prime   = prime_q;
    assign residue = residue_q;

    // R1: reset clears the visible state
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!done_q && !prime_q && residue_q == '0));

    // R2: accepted start seeds the residue and drops done
    assert_start_seed_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && exp_ok) |=> (residue_q == SEED && !done_q && busy));

    // R3: residue stays inside 0 .. 2^p-2 while running
    assert_res_range_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((residue_q & ~cfg_q.mask) == '0 && residue_q != cfg_q.mask));

    // R6: mid-round, configuration and residue are untouched by the inputs
    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !sqr_last) |=> ($stable(cfg_q) && $stable(residue_q)));

    // R7: finished result holds until a new start
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done_q && !start) |=> (done_q && $stable(prime_q) && $stable(residue_q)));

    // R8: out-of-range exponent completes at once as not prime
    assert_bad_exp_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && !exp_ok) |=> (done_q && !prime_q));
endmodule

// File: tb/sim_lucas_lehmer_top.sv
module sim_lucas_lehmer_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] exp_in = '0;
    logic         done;
    logic         prime;
    logic [W-1:0] residue;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    longint exp_q[$];
    bit     exp_prime;
    int     mon_p;
    bit     mon_go = 0;
    bit     mon_done = 0;

    always #4 clk = ~clk;

    lucas_lehmer_top #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .exp_in(exp_in),
        .done(done), .prime(prime), .residue(residue)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected residues on exact round boundaries.
    initial begin
        forever begin
            longint e;
            int     cp;
            int     n;
            wait (mon_go);
            cp = mon_p;
            @(posedge clk);
            @(negedge clk);
            e = exp_q.pop_front();
            chk(residue == W'(e), "R2", "seed residue", residue, e);
            chk(done == 1'b0, "R2", "done cleared on start", done, 0);
            n = exp_q.size();
            for (int k = 1; k <= n; k++) begin
                repeat (cp - 1) @(posedge clk);
                @(negedge clk);
                chk(done == 1'b0, "R5", "done early", done, 0);
                @(posedge clk);
                @(negedge clk);
                e = exp_q.pop_front();
                chk(residue == W'(e), "R3", $sformatf("residue round %0d p=%0d", k, cp), residue, e);
                if (k == n) begin
                    chk(done == 1'b1, "R5", "done at p*(p-2)", done, 1);
                    chk(prime == exp_prime, "R4", $sformatf("prime flag p=%0d", cp), prime, exp_prime);
                end else begin
                    chk(done == 1'b0, "R5", "done mid run", done, 0);
                end
            end
            mon_go   = 0;
            mon_done = 1;
        end
    end

    // Driver: builds expected sequence from the recurrence, then starts the run.
    task automatic run_case(input int pe, input bit disturb);
        longint m = (longint'(1) << pe) - 1;
        longint s = 4;
        exp_q.delete();
        exp_q.push_back(s);
        for (int k = 1; k <= pe - 2; k++) begin
            s = (s * s + m - 2) % m;
            exp_q.push_back(s);
        end
        exp_prime = (s == 0);
        @(negedge clk);
        mon_p    = pe;
        mon_done = 0;
        exp_in   = W'(pe);
        start    = 1'b1;
        mon_go   = 1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R6: new start and new exponent while busy must be ignored
            repeat (2 * pe) @(negedge clk);
            exp_in = W'(5);
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (mon_done);
    endtask

    task automatic bad_exp(input int v);
        @(negedge clk);
        exp_in = W'(v);
        start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R8", $sformatf("done for exponent %0d", v), done, 1);
        chk(prime == 1'b0, "R8", $sformatf("prime for exponent %0d", v), prime, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held_res;
        logic         held_prime;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(prime == 1'b0, "R1", "prime after reset", prime, 0);
        chk(residue == '0, "R1", "residue after reset", residue, 0);

        run_case(7, 0);   // R4 prime sequence 4,14,67,42,111,0
        // R7 result held while no start arrives
        held_res   = residue;
        held_prime = prime;
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R7", "done held", done, 1);
        chk(prime == held_prime, "R7", "prime held", prime, held_prime);
        chk(residue == held_res, "R7", "residue held", residue, held_res);

        bad_exp(2);       // R8 also drops a prior prime result
        run_case(11, 0);  // R4 composite, ends at 1736
        run_case(3, 0);
        run_case(4, 0);
        run_case(5, 0);
        run_case(13, 0);
        run_case(16, 0);
        run_case(11, 1);  // R6 disturbed run
        bad_exp(0);
        bad_exp(17);
        bad_exp(65535);
        run_case(7, 0);   // R7 fresh run after completion

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule